// File: doc/BRIEF.md
# Double-Fetch Instruction Word Assembler

This block builds 32-bit instruction words from a store that is only 16 bits wide. It makes two reads from that store in every instruction cycle. The block runs on a fast clock. An internal phase bit toggles on every edge and supplies the least significant bit of the store address. The processor's 12-bit instruction address supplies the upper bits. The half read while the phase is low becomes the upper half of the word. The half read while the phase is high comes from the next location up and becomes the lower half. The assembled word is registered and marked by a one-cycle valid strobe. The instruction rate is therefore half the fast-clock rate.

The block also drives three chip selects for the store. The first follows the diagnostic mode control. The second follows an extra instruction-address bit. The third is held active. In diagnostic (kernel) mode the store is deselected and the block substitutes a fixed no-operation word. An internal counter then replaces the processor address and sweeps every instruction location, so that the address path can be exercised without valid program contents.

Top module: `dfetch_top`

## Requirements
- R1: While `rstN` is low, `instrValid` is 0, `instrWord` is 0, the phase (`romAddr[0]`) is 0 and the diagnostic counter is 0. The phase is 0 in the first cycle after reset is released.
- R2: `romAddr[0]` equals the phase. The phase alternates 0,1,0,1 on successive clock cycles.
- R3: The store data sampled at the end of the phase-0 cycle lands in `instrWord[31:16]`. The data sampled at the end of the phase-1 cycle lands in `instrWord[15:0]`. The new word appears in the cycle after the phase-1 cycle and holds until the next word completes.
- R4: `instrValid` is 1 for exactly one cycle per instruction: the cycle after each phase-1 cycle. It is 0 in every other cycle.
- R5: `romCs[0]` is 1 exactly when `kernelMode` is 0. `romCs[1]` equals `instrBank`. `romCs[2]` is always 1. The store is enabled only when all three are 1.
- R6: In kernel mode each half is taken from parameter `NOP_WORD` (upper half in phase 0, lower half in phase 1). `romData` has no effect on the word.
- R7: In kernel mode `romAddr[12:1]` shows the diagnostic counter instead of `instrAddr`. The counter advances by one at the end of each phase-1 cycle and wraps from 4095 to 0.
- R8: Outside kernel mode `romAddr[12:1]` equals `instrAddr`. The diagnostic counter holds its value, and a later kernel period resumes from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; two cycles per instruction |
| rstN | input | 1 | Asynchronous active-low reset |
| instrAddr | input | 12 | Instruction address from the processor |
| instrBank | input | 1 | Extra instruction-address bit driving one chip select |
| kernelMode | input | 1 | Diagnostic mode: store disabled, NOP injected, address sweep |
| romData | input | 16 | Data read from the instruction store |
| romAddr | output | 13 | Store address: {instruction address, phase} |
| romCs | output | 3 | Active-high chip selects {fixed, bank, not kernel} |
| instrWord | output | 32 | Registered assembled instruction |
| instrValid | output | 1 | One-cycle strobe marking a new instruction |

## Verification
The bench keeps the default 12-bit address width. The counter wrap from 4095 to 0 is reached after 4096 kernel instructions, about 8200 clock cycles. It overrides `NOP_WORD` with a non-zero pattern (C0DE0F0F) so that an injected NOP cannot be confused with a cleared register or with the all-ones data seen from a deselected store. The store model returns a distinct value at every location, so a swapped half order or a wrong low address bit shows up in the word.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
  typedef struct packed {
    logic captureHi;
    logic completeWord;
    logic useNop;
  } fetchStrobes_t;
endpackage

// File: rtl/dfetch_ctrl.sv
module dfetch_ctrl
  import dfetch_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kernelMode,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              phase,
  output logic [ADDR_W-1:0] fetchAddr,
  output fetchStrobes_t     strobes
);
  localparam logic [ADDR_W-1:0] COUNT_MAX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] diagCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      diagCount <= '0;
    end else begin
      phase <= ~phase;
      if (phase && kernelMode) begin
        diagCount <= (diagCount == COUNT_MAX) ? '0 : diagCount + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.captureHi    = ~phase;
    strobes.completeWord = phase;
    strobes.useNop       = kernelMode;
    fetchAddr            = kernelMode ? diagCount : instrAddr;
  end

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !kernelMode |=> $stable(diagCount));

  // R7
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase && kernelMode && diagCount == COUNT_MAX) |=> diagCount == '0);

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase |=> !phase);
endmodule

// File: rtl/dfetch_datapath.sv
module dfetch_datapath
  import dfetch_pkg::*;
#(
  parameter int              HALF_W   = 16,
  parameter logic [2*HALF_W-1:0] NOP_WORD = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetchStrobes_t       strobes,
  input  logic [HALF_W-1:0]   romData,
  output logic [2*HALF_W-1:0] instrWord,
  output logic                instrValid
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] NOP_HI = NOP_WORD[WORD_W-1:HALF_W];
  localparam logic [HALF_W-1:0] NOP_LO = NOP_WORD[HALF_W-1:0];

  logic [HALF_W-1:0] hiHalf;
  logic [HALF_W-1:0] hiNext;
  logic [HALF_W-1:0] loNext;

  always_comb begin
    hiNext = strobes.useNop ? NOP_HI : romData;
    loNext = strobes.useNop ? NOP_LO : romData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiHalf     <= '0;
      instrWord  <= '0;
      instrValid <= 1'b0;
    end else begin
      instrValid <= strobes.completeWord;
      if (strobes.captureHi) hiHalf <= hiNext;
      if (strobes.completeWord) instrWord <= {hiHalf, loNext};
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !instrValid);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.completeWord |=> $stable(instrWord));

  // R6
  nop_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.completeWord && strobes.useNop && $past(strobes.useNop))
      |=> instrWord == NOP_WORD);
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
  import dfetch_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              HALF_W   = 16,
  parameter logic [2*HALF_W-1:0] NOP_WORD = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic                instrBank,
  input  logic                kernelMode,
  input  logic [HALF_W-1:0]   romData,
  output logic [ADDR_W:0]     romAddr,
  output logic [2:0]          romCs,
  output logic [2*HALF_W-1:0] instrWord,
  output logic                instrValid
);
  logic              phase;
  logic [ADDR_W-1:0] fetchAddr;
  fetchStrobes_t     strobes;

  dfetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .instrAddr(instrAddr),
    .phase(phase), .fetchAddr(fetchAddr), .strobes(strobes)
  );

  dfetch_datapath #(.HALF_W(HALF_W), .NOP_WORD(NOP_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .romData(romData),
    .instrWord(instrWord), .instrValid(instrValid)
  );

  always_comb begin
    romAddr = {fetchAddr, phase};
    romCs   = {1'b1, instrBank, ~kernelMode};
  end

  // R4
  valid_after_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |-> !romAddr[0]);

  // R8
  addr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !kernelMode |-> romAddr[ADDR_W:1] == instrAddr);
endmodule

// File: tb/dfetch_top_tb.sv
module dfetch_top_tb;
  localparam logic [31:0] NOP = 32'hC0DE_0F0F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] instrAddr = '0;
  logic        instrBank = 1'b0;
  logic        kernelMode = 1'b0;
  logic        forceJunk = 1'b0;
  logic [15:0] romData;
  logic [12:0] romAddr;
  logic [2:0]  romCs;
  logic [31:0] instrWord;
  logic        instrValid;

  int errors = 0;
  int checks = 0;
  int expCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] romFn(logic [12:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503;
    return t[15:0] ^ 16'h5A5A;
  endfunction

  always_comb begin
    if (forceJunk) romData = 16'h1234;
    else if (romCs == 3'b111) romData = romFn(romAddr);
    else romData = 16'hFFFF;
  end

  dfetch_top #(.ADDR_W(12), .HALF_W(16), .NOP_WORD(NOP)) u_dut (
    .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instrBank(instrBank),
    .kernelMode(kernelMode), .romData(romData), .romAddr(romAddr),
    .romCs(romCs), .instrWord(instrWord), .instrValid(instrValid)
  );

  task automatic check(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runInstr(logic [11:0] a, logic b, logic k);
    logic [11:0] upper;
    logic [31:0] expWord;
    if (romAddr[0] !== 1'b0) @(negedge clk);
    instrAddr = a; instrBank = b; kernelMode = k;
    #1;
    upper = k ? 12'(expCount) : a;
    if (k) expWord = NOP;
    else if (b) expWord = {romFn({upper, 1'b0}), romFn({upper, 1'b1})};
    else expWord = 32'hFFFF_FFFF;
    check(k ? "R7 addr" : "R8 addr", romAddr == {upper, 1'b0}, 32'(romAddr), 32'({upper, 1'b0}));
    check("R5 cs", romCs == {1'b1, b, ~k}, 32'(romCs), 32'({1'b1, b, ~k}));
    @(negedge clk);
    check("R2 phase", romAddr == {upper, 1'b1}, 32'(romAddr), 32'({upper, 1'b1}));
    check("R4 early", instrValid == 1'b0, 32'(instrValid), 32'd0);
    @(negedge clk);
    check(k ? "R6 word" : "R3 word", instrWord == expWord, instrWord, expWord);
    check("R4 pulse", instrValid == 1'b1, 32'(instrValid), 32'd1);
    if (k) expCount = (expCount + 1) % 4096;
  endtask

  localparam logic [13:0] VEC [0:7] = '{
    {1'b0, 1'b1, 12'h000}, {1'b0, 1'b1, 12'hFFF}, {1'b0, 1'b1, 12'h555},
    {1'b0, 1'b1, 12'hAAA}, {1'b0, 1'b0, 12'h123}, {1'b1, 1'b1, 12'h7FF},
    {1'b1, 1'b0, 12'h000}, {1'b0, 1'b1, 12'h800}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #12;
    check("R1 valid", instrValid == 1'b0, 32'(instrValid), 32'd0);
    check("R1 word", instrWord == 32'd0, instrWord, 32'd0);
    check("R1 phase", romAddr[0] == 1'b0, 32'(romAddr[0]), 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < 8; i++) runInstr(VEC[i][11:0], VEC[i][12], VEC[i][13]);

    // R4 strobe drops after one cycle
    @(negedge clk);
    check("R4 single", instrValid == 1'b0, 32'(instrValid), 32'd0);

    // R8 counter held across normal mode, then resumes
    runInstr(12'h3C3, 1'b1, 1'b0);
    runInstr(12'h3C3, 1'b1, 1'b1);

    // R6 romData ignored in kernel mode
    forceJunk = 1'b1;
    runInstr(12'h0AB, 1'b1, 1'b1);
    forceJunk = 1'b0;

    // R7 sweep with wrap 4095 -> 0
    for (int i = 0; i < 4100; i++) runInstr(12'h000, 1'b1, 1'b1);

    // R1 reset in mid-run
    @(negedge clk);
    rstN = 1'b0; kernelMode = 1'b1;
    #1;
    check("R1 mid valid", instrValid == 1'b0, 32'(instrValid), 32'd0);
    check("R1 mid word", instrWord == 32'd0, instrWord, 32'd0);
    check("R1 mid count", romAddr == 13'd0, 32'(romAddr), 32'd0);
    @(negedge clk); rstN = 1'b1; expCount = 0;
    runInstr(12'h456, 1'b1, 1'b1);
    runInstr(12'h456, 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule